// File: doc/BRIEF.md
# Locked-Rotor Supervisor

This block watches the three-bit Hall code of a brushless motor and decides whether the rotor is actually turning. On every change of the Hall code it flips a speed output, so a downstream timer can measure rotor speed from that square wave. It also runs a persistence counter clocked by a slow timing tick. That counter is cleared whenever the rotor makes real progress in the commanded direction. When the counter expires, the block raises a latched fault that the gate-drive logic uses to switch the bridge off.

Two kinds of lock are detected. The first is a stalled rotor, where no Hall edges arrive. The second is a rotor rocking back and forth between two adjacent codes, where edges keep arriving but no net rotation happens. Once raised, the fault stays set until one of three clear events occurs: a direction change, a long enough off-interval on the external chop input, or a power-up reset.

The slow timing clock is an analog oscillator in a real system. Here it arrives as a one-cycle `tick` pulse that is synchronous to `clk`. All pins are plain control and status levels. There is no streamed data, so there is no handshake.

Top module: `lrd_lock_monitor`

## Requirements
- R1: `speed_out` inverts one clock after any sampled change of `hall_code`. The first code sampled after reset sets the baseline and does not toggle it.
- R2: The forward order (`dir_sel`=1) is the cyclic Hall sequence 101, 100, 110, 010, 011, 001, and reverse (`dir_sel`=0) walks it backwards. A transition earns credit when it is a correct step and the transition before it was also a correct step. Credit clears the persistence count, so steady rotation in the selected direction never faults.
- R3: After 127 ticks with no credit, `lock_fault` rises one clock after the count reaches 127. The count saturates and never exceeds 127.
- R4: The following earn no credit: a wrong-order step, a reversal, an invalid code (000 or 111), and rocking between two codes. A step that follows a non-credit transition also earns no credit.
- R5: Once set, `lock_fault` stays high regardless of Hall activity until a clear event occurs. A chop-high interval shorter than 64 ticks is not a clear event.
- R6: A rising or falling edge of `dir_sel` clears `lock_fault` at the next clock and restarts the persistence count.
- R7: `pwm_off` held high for 64 ticks clears `lock_fault` on the following clock. While `pwm_off` stays high the fault stays clear. Taking `pwm_off` low restarts the 64-tick measurement.
- R8: An active-low `rst_n` clears `lock_fault`, `speed_out` and all counts.
- R9: While `brake_on` is high, the persistence count is held at zero, so no fault can be raised.
- R10: `lock_en`=0 holds the count at zero and forces `lock_fault` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| hall_code | input | 3 | Hall sensor code, bit 2 = phase A, bit 0 = phase C |
| dir_sel | input | 1 | Commanded direction, 1 = forward |
| pwm_off | input | 1 | External chop input, 1 = bridge chopped off |
| brake_on | input | 1 | Brake mode active |
| lock_en | input | 1 | Enables lock detection |
| tick | input | 1 | One-cycle pulse of the slow timing clock |
| speed_out | output | 1 | Toggles on every Hall transition |
| lock_fault | output | 1 | Latched locked-rotor fault |

## Verification
The bench applies four kinds of Hall pattern:
- **Clean forward rotation.** Shows that credit keeps the counter from expiring.
- **Clean reverse rotation** (after a direction edge). Shows the direction input really swaps the expected order.
- **A frozen code.** Exercises the pure stall path.
- **Rocking between two adjacent codes.** Edges keep toggling the speed output, yet the fault must still appear, which separates "edges present" from "rotation present".

The chop-high, brake and disable inputs are then layered on a stalled rotor. Short and long chop intervals show which of them clears the latch.

// File: rtl/lrd_pkg.sv
package lrd_pkg;
  localparam int HALL_W = 3;
  typedef logic [HALL_W-1:0] hall_t;

  function automatic logic code_ok(input hall_t c);
    return (c != 3'b000) && (c != 3'b111);
  endfunction

  // Successor code in the selected direction; forward order 101,100,110,010,011,001
  function automatic hall_t next_code(input hall_t c, input logic fwd);
    hall_t r;
    unique case (c)
      3'b101: r = fwd ? 3'b100 : 3'b001;
      3'b100: r = fwd ? 3'b110 : 3'b101;
      3'b110: r = fwd ? 3'b010 : 3'b100;
      3'b010: r = fwd ? 3'b011 : 3'b110;
      3'b011: r = fwd ? 3'b001 : 3'b010;
      3'b001: r = fwd ? 3'b101 : 3'b011;
      default: r = 3'b000;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/lrd_tick_timer.sv
module lrd_tick_timer #(
  parameter int LIMIT = 127
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clr)             cnt_q <= '0;
    else if (inc && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q == LIM);

  // R3: count saturates, never beyond its limit
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);

  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !done);
endmodule

// File: rtl/lrd_hall_tracker.sv
module lrd_hall_tracker
  import lrd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  hall_t hall_code,
  input  logic  dir_sel,
  output logic  speed_out,
  output logic  step_credit
);
  hall_t prev_q;
  logic  primed_q, speed_q, last_ok_q;
  logic  changed, good_step;

  assign changed     = primed_q && (hall_code != prev_q);
  assign good_step   = changed && code_ok(prev_q) &&
                       (hall_code == next_code(prev_q, dir_sel));
  assign step_credit = good_step && last_ok_q;
  assign speed_out   = speed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      primed_q  <= 1'b0;
      speed_q   <= 1'b0;
      last_ok_q <= 1'b0;
    end else begin
      prev_q   <= hall_code;
      primed_q <= 1'b1;
      if (changed) begin
        speed_q   <= ~speed_q;
        last_ok_q <= good_step;
      end
    end
  end

  // R1: every sampled code change flips the speed output
  a_r1_speed_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    changed |=> (speed_out != $past(speed_out)));

  a_r1_speed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && hall_code == prev_q) |=> $stable(speed_out));

  // R4: a reversal never earns credit
  a_r4_no_reverse_credit: assert property (@(posedge clk) disable iff (!rst_n)
    (changed && hall_code == next_code(prev_q, !dir_sel)) |-> !step_credit);
endmodule

// File: rtl/lrd_fault_latch.sv
module lrd_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_sel,
  input  logic lock_en,
  input  logic hold_done,
  input  logic lock_done,
  output logic fault,
  output logic dir_edge
);
  logic dir_q, primed_q, fault_q;

  assign dir_edge = primed_q && (dir_sel != dir_q);
  assign fault    = fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= 1'b0;
      primed_q <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      dir_q    <= dir_sel;
      primed_q <= 1'b1;
      if (!lock_en)                  fault_q <= 1'b0;
      else if (dir_edge || hold_done) fault_q <= 1'b0;
      else if (lock_done)            fault_q <= 1'b1;
    end
  end

  // R6: direction edge clears the latch
  a_r6_dir_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
    dir_edge |=> !fault);

  // R5: latch holds without a clear event
  a_r5_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && lock_en && !dir_edge && !hold_done) |=> fault);

  // R10: disabled detection forces the fault low
  a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_en |=> !fault);
endmodule

// File: rtl/lrd_lock_monitor.sv
module lrd_lock_monitor
  import lrd_pkg::*;
#(
  parameter int LOCK_TICKS  = 127,
  parameter int CLEAR_TICKS = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_code,
  input  logic       dir_sel,
  input  logic       pwm_off,
  input  logic       brake_on,
  input  logic       lock_en,
  input  logic       tick,
  output logic       speed_out,
  output logic       lock_fault
);
  logic step_credit, dir_edge, hold_done, lock_done, persist_clr;

  lrd_hall_tracker u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .hall_code   (hall_code),
    .dir_sel     (dir_sel),
    .speed_out   (speed_out),
    .step_credit (step_credit)
  );

  assign persist_clr = step_credit | brake_on | ~lock_en | lock_fault |
                       hold_done | dir_edge;

  lrd_tick_timer #(.LIMIT(LOCK_TICKS)) u_persist (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (persist_clr),
    .inc   (tick),
    .done  (lock_done)
  );

  lrd_tick_timer #(.LIMIT(CLEAR_TICKS)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (~pwm_off),
    .inc   (tick),
    .done  (hold_done)
  );

  lrd_fault_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_sel   (dir_sel),
    .lock_en   (lock_en),
    .hold_done (hold_done),
    .lock_done (lock_done),
    .fault     (lock_fault),
    .dir_edge  (dir_edge)
  );

  // R9: a brake held over two clocks keeps the fault from rising
  a_r9_brake_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (brake_on && $past(brake_on) && !lock_fault) |=> !lock_fault);

  // R7: a completed chop-high interval keeps the fault clear
  a_r7_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hold_done |=> !lock_fault);
endmodule

// File: tb/lrd_lock_monitor_test.sv
module lrd_lock_monitor_test;
  logic clk = 0, rst_n = 0;
  logic [2:0] hall_code = 3'b101;
  logic dir_sel = 1, pwm_off = 0, brake_on = 0, lock_en = 1, tick = 0;
  logic speed_out, lock_fault;
  int checks = 0, fails = 0, ph = 0;
  bit tick_on = 1;

  always #2.5 clk = ~clk;

  lrd_lock_monitor uut (.*);

  // behavioural reference
  int seq [6] = '{5, 4, 6, 2, 3, 1};
  int m_prev, m_cnt, m_hold;
  bit m_primed, m_speed, m_fault, m_dirq, m_lastok;

  function automatic int pos(input int c);
    for (int i = 0; i < 6; i++) if (seq[i] == c) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = 0; m_cnt = 0; m_hold = 0;
      m_primed = 0; m_speed = 0; m_fault = 0; m_dirq = 0; m_lastok = 0;
    end else begin
      bit trans, good, credit, dedge, hdone, cdone, nf;
      int pp, pn;
      pp = pos(m_prev); pn = pos(int'(hall_code));
      trans  = m_primed && (int'(hall_code) != m_prev);
      good   = trans && pp >= 0 && pn >= 0 && pn == (pp + (dir_sel ? 1 : 5)) % 6;
      credit = good && m_lastok;
      dedge  = m_primed && (dir_sel != m_dirq);
      hdone  = (m_hold == 64);
      cdone  = (m_cnt == 127);
      if (!lock_en) nf = 0;
      else if (dedge || hdone) nf = 0;
      else if (cdone) nf = 1;
      else nf = m_fault;
      if (credit || brake_on || !lock_en || m_fault || hdone || dedge) m_cnt = 0;
      else if (tick && m_cnt < 127) m_cnt++;
      if (!pwm_off) m_hold = 0;
      else if (tick && m_hold < 64) m_hold++;
      if (trans) begin m_speed = !m_speed; m_lastok = good; end
      m_fault = nf;
      m_prev = int'(hall_code); m_dirq = dir_sel; m_primed = 1;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_n) begin
        chk("R1 speed", speed_out, m_speed);
        chk("R3 fault", lock_fault, m_fault);
      end
      tick = tick_on && (ph == 3);
      ph = (ph + 1) % 4;
    end
  endtask

  task automatic spin(input int steps, input bit fwd, input int gap);
    int k;
    k = pos(int'(hall_code));
    if (k < 0) k = 0;
    for (int i = 0; i < steps; i++) begin
      k = (k + (fwd ? 1 : 5)) % 6;
      hall_code = 3'(seq[k]);
      run(gap);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    run(4);
    chk("R8 reset speed", speed_out, 0);
    chk("R8 reset fault", lock_fault, 0);
    rst_n = 1;
    run(3);
    chk("R1 no toggle on first sample", speed_out, 0);
    // R2: forward rotation, steps every 40 cycles for ~ 3x timeout
    spin(40, 1, 40);
    chk("R2 forward no fault", lock_fault, 0);
    // R3: stall
    run(127 * 4 + 12);
    chk("R3 stall fault", lock_fault, 1);
    spin(6, 1, 20);
    chk("R5 sticky under rotation", lock_fault, 1);
    // R6: direction edge clears, reverse rotation OK
    dir_sel = 0;
    run(2);
    chk("R6 dir edge clears", lock_fault, 0);
    spin(40, 0, 40);
    chk("R2 reverse no fault", lock_fault, 0);
    // R4: rocking between two codes
    for (int i = 0; i < 30; i++) begin
      hall_code = (i % 2) ? 3'b101 : 3'b100;
      run(30);
    end
    chk("R4 rocking fault", lock_fault, 1);
    // R5: short chop-high does not clear
    pwm_off = 1; run(30 * 4); pwm_off = 0; run(4);
    chk("R5 short chop keeps fault", lock_fault, 1);
    // R7: long chop-high clears
    pwm_off = 1; run(66 * 4);
    chk("R7 long chop clears", lock_fault, 0);
    run(200 * 4);
    chk("R7 stays clear while high", lock_fault, 0);
    pwm_off = 0;
    // R9: brake during stall
    brake_on = 1; run(200 * 4);
    chk("R9 brake no fault", lock_fault, 0);
    brake_on = 0; run(128 * 4 + 8);
    chk("R3 fault after brake", lock_fault, 1);
    // R10: disable
    lock_en = 0; run(3);
    chk("R10 disable clears", lock_fault, 0);
    run(200 * 4);
    chk("R10 stays low", lock_fault, 0);
    lock_en = 1;
    // R4: invalid code stall
    hall_code = 3'b111; run(130 * 4);
    chk("R4 invalid code fault", lock_fault, 1);
    // R8: reset clears
    #1 rst_n = 0; run(2);
    chk("R8 reset clears fault", lock_fault, 0);
    rst_n = 1; run(4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule